// File: doc/BRIEF.md
# Heun-Integrated Chaotic Weight Generator

This block steps a three-variable chaotic system of the Lü family forward in time with a two-phase Heun (predictor, then corrector) integrator. All arithmetic is signed fixed point. After every completed step the three state variables are folded into 8-bit values, and these drive the weight stream of a convolution-based image scrambler. The state is seeded from three input words. The seeding happens at reset, and a later `load` pulse seeds it again and restarts the sequence.

A step begins only when the consumer raises `ready` while the integrator is idle. The predictor cycle registers the intermediate state. The corrector cycle writes the new state and presents it through `out_valid`. A weight set that has not been taken stays on the output unchanged until `ready` accepts it. With `ready` held high, a new set appears every second cycle.

Top module: `chaos_heun_osc`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads the state from `seed_x`, `seed_y` and `seed_z`, drops `out_valid` and puts the integrator in its idle phase. The weights then show the seeds.
- R2: A high `load` takes priority over everything except reset. It loads the seeds, clears `out_valid` and abandons any step in progress, including one in its corrector cycle.
- R3: A step starts only on an edge where the integrator is idle and `ready` is high. The step lasts exactly two cycles, and the state changes only at the edge that ends the corrector cycle. With `ready` low while idle, state and outputs stay frozen.
- R4: The system is dx = 36(y−x), dy = 20y − xz and dz = xy − 3z. The predictor is p = s + q(h, f(s)), where h = 10486, which is 0.01 in the number format.
- R5: The corrected state is s' = s + q(5243, f(s) + f(p)). The constant 5243 is h/2 in the number format.
- R6: Numbers are signed 32-bit words with 20 fraction bits. q(a,b) forms the 64-bit signed product, shifts it right arithmetically by 20 and keeps the low 32 bits. All sums and differences wrap at 32 bits.
- R7: Each weight is the integer part of the magnitude of its state word, taken modulo 255. It therefore lies in 0 to 254: an integer part of 254 gives 254 and one of 255 gives 0.
- R8: `weights[7:0]` carries the Y weight, `weights[15:8]` the Z weight and `weights[23:16]` the X weight.
- R9: `out_valid` rises on the edge that ends a corrector cycle. While `ready` is low it holds, together with the weights. It clears on the edge where `ready` is high, because that edge completes the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seeds |
| load | input | 1 | Reload seeds and restart the sequence |
| seed_x | input | 32 | Initial x, signed 12.20 fixed point |
| seed_y | input | 32 | Initial y, signed 12.20 fixed point |
| seed_z | input | 32 | Initial z, signed 12.20 fixed point |
| ready | input | 1 | Consumer accepts the current set and permits the next step |
| out_valid | output | 1 | A fresh weight set is present |
| weights | output | 24 | Y, Z, X weights from low byte to high byte |

## Verification
The embedded properties hold on every cycle for these facts: each weight stays under 255, a held set stays unchanged while `ready` is low, an idle integrator leaves the state alone without `ready`, a load clears the valid flag and the phase, and a corrector cycle always raises `out_valid`. Only the bench's reference model can show that the numbers themselves are correct. That covers the exact predictor and corrector arithmetic, the truncation and wrap of the fixed-point products, the Y/Z/X byte order, and the modulo results at the 254/255 boundary for negative seeds. The bench drives the model and the design through long free runs, irregular `ready` patterns and a load that interrupts a corrector cycle.

// File: rtl/chaos_pkg.sv
package chaos_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_CORR = 1'b1
   } phase_e;

   // Weight lane positions on the output bus; the consumer depends on this order.
   localparam int LANE_Y = 0;
   localparam int LANE_Z = 1;
   localparam int LANE_X = 2;
   localparam int LANES  = 3;

   // Fixed-point multiply: full signed product, arithmetic right shift by frac.
   function automatic logic signed [63:0] fx_mul(input logic signed [63:0] a,
                                                 input logic signed [63:0] b,
                                                 input int frac);
      return (a * b) >>> frac;
   endfunction

endpackage

// File: rtl/chaos_deriv.sv
module chaos_deriv
   import chaos_pkg::*;
#(
   parameter int W     = 32,
   parameter int FRAC  = 20,
   parameter int A_INT = 36,
   parameter int B_INT = 3,
   parameter int C_INT = 20
) (
   input  logic signed [W-1:0] x,
   input  logic signed [W-1:0] y,
   input  logic signed [W-1:0] z,
   output logic signed [W-1:0] dx,
   output logic signed [W-1:0] dy,
   output logic signed [W-1:0] dz
);

   localparam logic signed [W-1:0] A_Q = W'(longint'(A_INT) <<< FRAC);
   localparam logic signed [W-1:0] B_Q = W'(longint'(B_INT) <<< FRAC);
   localparam logic signed [W-1:0] C_Q = W'(longint'(C_INT) <<< FRAC);

   function automatic logic signed [W-1:0] qm(input logic signed [W-1:0] a,
                                              input logic signed [W-1:0] b);
      return W'(fx_mul(64'(a), 64'(b), FRAC));
   endfunction

   always_comb begin
      dx = qm(A_Q, y - x);
      dy = qm(C_Q, y) - qm(x, z);
      dz = qm(x, y) - qm(B_Q, z);
   end

endmodule

// File: rtl/chaos_weight.sv
module chaos_weight #(
   parameter int W    = 32,
   parameter int FRAC = 20,
   parameter int WW   = 8,
   parameter int MOD  = 255
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] v,
   output logic [WW-1:0]       w
);

   localparam int IW = W - FRAC;

   logic [W-1:0]  mag;
   logic [IW-1:0] ipart;

   generate
      if (MOD < 2 || MOD > (1 << WW)) begin : g_bad_mod
         $error("chaos_weight: MOD must fit in the weight width");
      end
   endgenerate

   always_comb begin
      mag   = v[W-1] ? (~v + 1'b1) : v;
      ipart = mag[W-1:FRAC];
      w     = WW'(32'(ipart) % MOD);
   end

   a_r7_weight_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(w) < MOD);

endmodule

// File: rtl/chaos_heun_osc.sv
module chaos_heun_osc
   import chaos_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int FRAC        = 20,
   parameter int WW          = 8,
   parameter int A_INT       = 36,
   parameter int B_INT       = 3,
   parameter int C_INT       = 20,
   parameter int STEP_INV    = 100,
   parameter int MOD         = 255,
   parameter bit SHARE_DERIV = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [WIDTH-1:0]       seed_x,
   input  logic [WIDTH-1:0]       seed_y,
   input  logic [WIDTH-1:0]       seed_z,
   input  logic                   ready,
   output logic                   out_valid,
   output logic [LANES*WW-1:0]    weights
);

   localparam longint ONE_Q = longint'(1) <<< FRAC;
   localparam logic signed [WIDTH-1:0] H_Q  = WIDTH'((ONE_Q + STEP_INV / 2) / STEP_INV);
   localparam logic signed [WIDTH-1:0] HH_Q = WIDTH'((ONE_Q + STEP_INV) / (2 * STEP_INV));

   generate
      if (WIDTH > 32 || FRAC >= WIDTH || FRAC < 1) begin : g_bad_fmt
         $error("chaos_heun_osc: unsupported fixed-point format");
      end
      if (STEP_INV < 2) begin : g_bad_step
         $error("chaos_heun_osc: step must be below one");
      end
   endgenerate

   function automatic logic signed [WIDTH-1:0] qm(input logic signed [WIDTH-1:0] a,
                                                  input logic signed [WIDTH-1:0] b);
      return WIDTH'(fx_mul(64'(a), 64'(b), FRAC));
   endfunction

   // ---------------- state ----------------
   phase_e ph;
   logic signed [WIDTH-1:0] sx, sy, sz;
   logic signed [WIDTH-1:0] px, py, pz;
   logic                    vld;
   logic                    go;

   // derivative of current state (fs) and of predictor (fp)
   logic signed [WIDTH-1:0] fsx, fsy, fsz;
   logic signed [WIDTH-1:0] fpx, fpy, fpz;

   assign go = (ph == PH_IDLE) && ready;

   generate
      if (SHARE_DERIV) begin : g_shared
         // One derivative unit, time-shared between the two phases.
         logic signed [WIDTH-1:0] ix, iy, iz, dx, dy, dz;
         logic signed [WIDTH-1:0] f0x, f0y, f0z;

         always_comb begin
            ix = (ph == PH_CORR) ? px : sx;
            iy = (ph == PH_CORR) ? py : sy;
            iz = (ph == PH_CORR) ? pz : sz;
         end

         chaos_deriv #(.W(WIDTH), .FRAC(FRAC), .A_INT(A_INT), .B_INT(B_INT), .C_INT(C_INT))
            u_deriv (.x(ix), .y(iy), .z(iz), .dx(dx), .dy(dy), .dz(dz));

         always_ff @(posedge clk) begin
            if (go) begin
               f0x <= dx;
               f0y <= dy;
               f0z <= dz;
            end
         end

         always_comb begin
            fsx = (ph == PH_IDLE) ? dx : f0x;
            fsy = (ph == PH_IDLE) ? dy : f0y;
            fsz = (ph == PH_IDLE) ? dz : f0z;
            fpx = dx;
            fpy = dy;
            fpz = dz;
         end
      end else begin : g_dual
         // Two derivative units; the state is unchanged across the step.
         chaos_deriv #(.W(WIDTH), .FRAC(FRAC), .A_INT(A_INT), .B_INT(B_INT), .C_INT(C_INT))
            u_deriv_s (.x(sx), .y(sy), .z(sz), .dx(fsx), .dy(fsy), .dz(fsz));
         chaos_deriv #(.W(WIDTH), .FRAC(FRAC), .A_INT(A_INT), .B_INT(B_INT), .C_INT(C_INT))
            u_deriv_p (.x(px), .y(py), .z(pz), .dx(fpx), .dy(fpy), .dz(fpz));
      end
   endgenerate

   // predictor and corrector datapaths
   logic signed [WIDTH-1:0] prx, pry, prz;
   logic signed [WIDTH-1:0] nx, ny, nz;

   always_comb begin
      prx = sx + qm(H_Q, fsx);
      pry = sy + qm(H_Q, fsy);
      prz = sz + qm(H_Q, fsz);
      nx  = sx + qm(HH_Q, fsx + fpx);
      ny  = sy + qm(HH_Q, fsy + fpy);
      nz  = sz + qm(HH_Q, fsz + fpz);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         sx  <= seed_x;
         sy  <= seed_y;
         sz  <= seed_z;
         ph  <= PH_IDLE;
         vld <= 1'b0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (ready) begin
                  px  <= prx;
                  py  <= pry;
                  pz  <= prz;
                  vld <= 1'b0;
                  ph  <= PH_CORR;
               end
            end
            PH_CORR: begin
               sx  <= nx;
               sy  <= ny;
               sz  <= nz;
               vld <= 1'b1;
               ph  <= PH_IDLE;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign out_valid = vld;

   // ---------------- weight lanes ----------------
   logic signed [WIDTH-1:0] lane_v [LANES];

   always_comb begin
      lane_v[LANE_Y] = sy;
      lane_v[LANE_Z] = sz;
      lane_v[LANE_X] = sx;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      chaos_weight #(.W(WIDTH), .FRAC(FRAC), .WW(WW), .MOD(MOD))
         u_wt (.clk(clk), .rst_n(rst_n), .v(lane_v[l]), .w(weights[l*WW +: WW]));
   end

   // ---------------- assertions ----------------
   a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!out_valid && ph == PH_IDLE));

   a_r3_idle_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && ph == PH_IDLE) |=> $stable({sx, sy, sz}));

   a_r3_no_step_without_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !ready && ph == PH_IDLE) |=> (ph == PH_IDLE && $stable(weights)));

   a_r9_valid_after_corr: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && ph == PH_CORR) |=> (out_valid && ph == PH_IDLE));

   a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && out_valid && !ready) |=> (out_valid && $stable(weights)));

endmodule

// File: tb/tb_chaos_heun_osc.sv
`timescale 1ns/1ps
module tb_chaos_heun_osc;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        load;
   logic        ready;
   logic [31:0] seed_x, seed_y, seed_z;
   logic        out_valid;
   logic [23:0] weights;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   chaos_heun_osc dut (
      .clk(clk), .rst_n(rst_n), .load(load),
      .seed_x(seed_x), .seed_y(seed_y), .seed_z(seed_z),
      .ready(ready), .out_valid(out_valid), .weights(weights)
   );

   // ---------------- reference model ----------------
   int mx, my, mz, mpx, mpy, mpz;
   bit mcorr, mvld;

   function automatic int mq(int a, int b);
      longint p;
      p = longint'(a) * longint'(b);
      return int'(p >>> 20);
   endfunction

   task automatic deriv(input int x, input int y, input int z,
                        output int dx, output int dy, output int dz);
      dx = mq(36 << 20, y - x);
      dy = mq(20 << 20, y) - mq(x, z);
      dz = mq(x, y) - mq(3 << 20, z);
   endtask

   function automatic int wt(int v);
      longint a;
      a = (v < 0) ? -longint'(v) : longint'(v);
      return int'((a >> 20) % 255);
   endfunction

   task automatic model_edge();
      int ax, ay, az, bx, by, bz;
      if (!rst_n || load) begin
         mx = seed_x; my = seed_y; mz = seed_z;
         mcorr = 1'b0; mvld = 1'b0;
      end else if (!mcorr) begin
         if (ready) begin
            deriv(mx, my, mz, ax, ay, az);
            mpx = mx + mq(10486, ax);
            mpy = my + mq(10486, ay);
            mpz = mz + mq(10486, az);
            mvld = 1'b0;
            mcorr = 1'b1;
         end
      end else begin
         deriv(mx, my, mz, ax, ay, az);
         deriv(mpx, mpy, mpz, bx, by, bz);
         mx = mx + mq(5243, ax + bx);
         my = my + mq(5243, ay + by);
         mz = mz + mq(5243, az + bz);
         mvld = 1'b1;
         mcorr = 1'b0;
      end
   endtask

   task automatic compare(input string tag);
      logic [23:0] exp_w;
      exp_w = {8'(wt(mx)), 8'(wt(mz)), 8'(wt(my))};
      checks++;
      if (out_valid !== mvld || weights !== exp_w) begin
         errors++;
         $display("FAIL %s: actual valid=%0b weights=%06h, expected valid=%0b weights=%06h",
                  tag, out_valid, weights, mvld, exp_w);
      end
   endtask

   // Called just after a falling edge: drive, clock, update model, compare.
   task automatic tick(input logic r, input logic l, input string tag);
      ready = r;
      load  = l;
      @(posedge clk);
      model_edge();
      #1;
      compare(tag);
      @(negedge clk);
   endtask

   initial begin
      rst_n  = 1'b0;
      load   = 1'b0;
      ready  = 1'b0;
      seed_x = 32'h0010_0000;   // 1.0
      seed_y = 32'h0010_0000;
      seed_z = 32'h0010_0000;
      mx = 0; my = 0; mz = 0; mpx = 0; mpy = 0; mpz = 0;
      mcorr = 1'b0; mvld = 1'b0;
      @(negedge clk);

      // R1: reset loads seeds, valid low
      for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, "R1 reset");
      rst_n = 1'b1;

      // R3: idle without ready leaves everything frozen
      for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, "R3 idle no ready");

      // R4 R5 R6 R8: free run with ready high
      for (int i = 0; i < 240; i++) tick(1'b1, 1'b0, "R4 R5 R6 R8 free run");

      // R3 R9: irregular ready, held sets
      for (int i = 0; i < 300; i++)
         tick(((i % 3) != 0) && ((i % 7) != 5), 1'b0, "R3 R9 irregular ready");

      // R2 R7: load boundary seeds; x=-2.5 -> 2, y=300.0 -> 45, z=-255.x -> 0
      seed_x = -32'sd2621440;
      seed_y = 32'(300 << 20);
      seed_z = -(32'(255 << 20) + 32'd5);
      tick(1'b0, 1'b1, "R2 load");
      for (int i = 0; i < 2; i++) tick(1'b0, 1'b0, "R7 R8 boundary weights");
      checks++;
      if (weights !== 24'h02_00_2D) begin
         errors++;
         $display("FAIL R7: actual weights=%06h, expected 02002d", weights);
      end

      // R2: load during the corrector cycle abandons the step
      seed_x = 32'h0008_0000;                    // 0.5   -> 0
      seed_y = -32'sd3407872;                    // -3.25 -> 3
      seed_z = 32'(254 << 20) + 32'h000E_0000;   // 254.875 -> 254
      tick(1'b1, 1'b0, "R2 start step");
      tick(1'b0, 1'b1, "R2 load in corrector");
      tick(1'b0, 1'b0, "R2 abandoned step");
      checks++;
      if (out_valid !== 1'b0 || weights !== 24'h00_FE_03) begin
         errors++;
         $display("FAIL R2: actual valid=%0b weights=%06h, expected valid=0 weights=00fe03",
                  out_valid, weights);
      end

      // R4 R5 R6 R9: run from the new seeds
      for (int i = 0; i < 200; i++) tick(1'b1, 1'b0, "R4 R5 R6 R9 reseeded run");

      // R1: reset during a run
      rst_n = 1'b0;
      tick(1'b1, 1'b0, "R1 reset mid run");
      rst_n = 1'b1;
      for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, "R1 R5 after reset");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule